// File: doc/BRIEF.md
# Reference Frequency Ppm Monitor

The block decides whether a reference clock runs within a parts-per-million window around its expected rate. It counts the pulses of a reference edge strobe during a fixed gate window. The gate is timed by the local master clock. At the end of each window it compares the pulse count with a lower and an upper bound, and it registers the result as a single monitor flag. That flag holds its value until the next window closes.

Four nominal reference rates are supported. They are 19.44 MHz, 8 kHz, 1.544 MHz and 2.048 MHz. A two-bit select input chooses the rate. The block captures that input only while reset is asserted, so a new rate takes effect at the next reset.

For every select code, the expected pulse count per window is a parameter. The bounds are derived from it and from a tolerance parameter in ppm, which defaults to 12. The gate length is also a parameter, so simulation can use short windows.

Top module: `ref_ppm_monitor`

## Requirements
- R1: While reset is asserted, and after reset is released until the first window closes, the monitor flag is low.
- R2: The flag changes only at the clock edge that ends a window of GATE_CYC master-clock cycles counted from reset release. Between those edges it holds its last value.
- R3: The flag is driven high when the window's pulse count is below NOM - D or above NOM + D, where D = floor(NOM * TOL_PPM / 1000000).
- R4: The flag is driven low when the count lies within [NOM - D, NOM + D], bounds included.
- R5: Select code 00 uses NOM_0 (19.44 MHz), 01 uses NOM_1 (8 kHz), 10 uses NOM_2 (1.544 MHz) and 11 uses NOM_3 (2.048 MHz).
- R6: The select input is captured only while reset is asserted. Changes after reset release have no effect on the limits until the next reset.
- R7: A window with zero reference pulses always drives the flag high.
- R8: A strobe in the last cycle of a window is counted in that window. Each window starts again from a count of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high; the select input is captured while it is high |
| ref_stb | input | 1 | One-cycle reference edge strobe, already synchronous to clk |
| freq_sel | input | 2 | Nominal reference rate select |
| mon_flag | output | 1 | High when the reference was out of the ppm window in the last full window |

## Verification
Faults in the internal state can only appear at the port when a window closes.

- A gate counter that is off by a cycle moves the flag update away from the GATE_CYC boundary. A count that leaks across windows shifts the next verdict. The flag is sampled one cycle after every expected boundary and at the middle of every window, so either fault shows within one window.
- A wrong bound, a bound that excludes its own value, or a wrong select decode gives the wrong verdict. Windows placed exactly on, and one pulse outside, each bound expose these faults in the window concerned.
- A select input that is captured after reset changes the limits in use. It shows in the first window after the pin moves.

// File: rtl/ref_ppm_monitor.sv
module ref_ppm_monitor #(
  parameter int unsigned  GATE_CYC = 40_000_000,
  parameter longint       NOM_0    = 38_880_000,
  parameter longint       NOM_1    = 16_000,
  parameter longint       NOM_2    = 3_088_000,
  parameter longint       NOM_3    = 4_096_000,
  parameter longint       TOL_PPM  = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       ref_stb,
  input  logic [1:0] freq_sel,
  output logic       mon_flag
);

  localparam int CW = $clog2(GATE_CYC + 1);
  localparam longint D0 = NOM_0 * TOL_PPM / 1_000_000;
  localparam longint D1 = NOM_1 * TOL_PPM / 1_000_000;
  localparam longint D2 = NOM_2 * TOL_PPM / 1_000_000;
  localparam longint D3 = NOM_3 * TOL_PPM / 1_000_000;

  logic [1:0]    sel_q;
  logic [CW-1:0] gcnt;
  logic [CW-1:0] ecnt;
  logic          win_end;
  logic [CW:0]   final_cnt;
  longint        lo_lim, hi_lim;
  logic          out_of_range;

  assign win_end   = (gcnt == CW'(GATE_CYC - 1));
  assign final_cnt = {1'b0, ecnt} + {{CW{1'b0}}, ref_stb};

  always_comb begin
    case (sel_q)
      2'b00:   begin lo_lim = NOM_0 - D0; hi_lim = NOM_0 + D0; end
      2'b01:   begin lo_lim = NOM_1 - D1; hi_lim = NOM_1 + D1; end
      2'b10:   begin lo_lim = NOM_2 - D2; hi_lim = NOM_2 + D2; end
      default: begin lo_lim = NOM_3 - D3; hi_lim = NOM_3 + D3; end
    endcase
  end

  assign out_of_range = (final_cnt == '0) ||
                        (longint'(final_cnt) < lo_lim) ||
                        (longint'(final_cnt) > hi_lim);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= freq_sel;
      gcnt     <= '0;
      ecnt     <= '0;
      mon_flag <= 1'b0;
    end else if (win_end) begin
      gcnt     <= '0;
      ecnt     <= '0;
      mon_flag <= out_of_range;
    end else begin
      gcnt     <= gcnt + 1'b1;
      ecnt     <= final_cnt[CW-1:0];
    end
  end

  assert_reset_low_R1: assert property (@(posedge clk) rst |=> !mon_flag);
  assert_hold_between_R2: assert property (@(posedge clk) disable iff (rst)
    !win_end |=> $stable(mon_flag));
  assert_sel_frozen_R6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(sel_q));
  assert_zero_edges_R7: assert property (@(posedge clk) disable iff (rst)
    (win_end && ecnt == '0 && !ref_stb) |=> mon_flag);
  assert_count_bounded_R8: assert property (@(posedge clk) disable iff (rst)
    ecnt <= gcnt);

endmodule

// File: tb/ref_ppm_monitor_tb_top.sv
module ref_ppm_monitor_tb_top;
  localparam int GATE = 400;
  localparam int NOMS [4] = '{200, 100, 40, 300};
  localparam int DELS [4] = '{10, 5, 2, 15};

  logic clk = 0, rst = 1, ref_stb = 0;
  logic [1:0] freq_sel = 2'b00;
  logic mon_flag;
  int checks = 0, errors = 0;
  bit exp_q[$];
  bit last_exp = 0;
  int mcnt = 0;

  ref_ppm_monitor #(.GATE_CYC(GATE), .NOM_0(200), .NOM_1(100), .NOM_2(40),
                    .NOM_3(300), .TOL_PPM(50_000)) dut_i (
    .clk(clk), .rst(rst), .ref_stb(ref_stb), .freq_sel(freq_sel), .mon_flag(mon_flag));

  always #4 clk = ~clk;

  task automatic check(input string req, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  always begin
    @(posedge clk);
    if (rst) mcnt = 0;
    else begin
      mcnt++;
      if (mcnt == GATE) begin
        mcnt = 0;
        #1;
        if (exp_q.size() > 0) check("R2/R3/R4 window verdict", mon_flag, exp_q.pop_front());
      end
    end
  end

  task automatic do_reset(input logic [1:0] s);
    @(negedge clk);
    rst = 1; freq_sel = s; ref_stb = 0;
    repeat (3) @(negedge clk);
    check("R1 flag low in reset", mon_flag, 1'b0);
    rst = 0; last_exp = 0;
  endtask

  task automatic window(input int n, input bit exp, input bit last_slot = 0);
    exp_q.push_back(exp);
    for (int i = 0; i < GATE; i++) begin
      ref_stb = last_slot ? (i >= GATE - n) : (i < n);
      if (i == GATE / 2) check("R2 flag held mid-window", mon_flag, last_exp);
      @(negedge clk);
    end
    ref_stb = 0;
    last_exp = exp;
  endtask

  task automatic sweep(input int s);
    do_reset(2'(s));
    window(NOMS[s], 0);
    window(NOMS[s] - DELS[s], 0);
    window(NOMS[s] - DELS[s] - 1, 1);
    window(NOMS[s] + DELS[s], 0);
    window(NOMS[s] + DELS[s] + 1, 1);
  endtask

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R1: first window unfinished keeps flag low; R5 each code its own limits; R3/R4 bounds
    for (int s = 0; s < 4; s++) sweep(s);
    // R7: zero edges
    do_reset(2'b01);
    window(0, 1);
    window(100, 0);
    // R8: strobe in last cycle counts; count restarts each window
    do_reset(2'b10);
    window(38, 0, 1);
    window(37, 1, 1);
    window(42, 0, 1);
    // R6: select moves after reset, limits of code 01 stay
    do_reset(2'b01);
    freq_sel = 2'b11;
    window(100, 0);
    window(300, 1);
    @(negedge clk);
    check("R5/R6 queue drained", exp_q.size() == 0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule